// File: doc/BRIEF.md
# Stereo Bitstream DAC Sample Controller

This block takes stereo audio as pairs of 16-bit two's-complement samples and turns each channel into a one-bit oversampled stream. Each channel has its own first-order delta-sigma modulator. A host drives a small register bus. One 32-bit write carries both channels: the low halfword is channel 0 and the high halfword is channel 1. The block runs in one clock domain. That clock is the conversion clock, and it runs at 256 times the sample rate, so one sample frame lasts 256 cycles.

While the block is enabled, a frame counter marks a boundary every 256 cycles. At a boundary, a sample pair written during the frame moves into the modulators. A ready status bit tells the host that the next pair may be written. If a boundary arrives and no new pair was written, an underrun status bit is set and the modulators keep converting the previous pair. Status bits clear when the status register is read, or when the host writes ones to a clear register. A mask selects which status bits drive the interrupt line.

Top module: `stereo_sdm_dac`

## Requirements
- R1: After reset the control, mask, status and sample-pair registers read zero, and `irq` and both `dac_out` bits are low.
- R2: While disabled (control bit 0 clear), writes to the data register are ignored. The frame counter stays at zero, no status bit is set, and `dac_out` is low one cycle after the enable bit clears.
- R3: Status bit 0 (ready) sets in the cycle after a control write that turns the block on. It also sets at every frame boundary that loads a new pair into the modulators.
- R4: A frame boundary occurs on every 256th enabled cycle. If no data write arrived since the previous boundary, status bit 1 (underrun) sets at that boundary and the previously loaded pair is converted again.
- R5: A pair written during a frame reaches the modulators only at the next boundary, and the last write in the frame wins. A write made in the boundary cycle itself is loaded at that boundary and counts as on time.
- R6: A status read returns the bits as they were before the read and then clears them. Writing ones to the clear register clears the matching bits. A bit that is set in the same cycle as a clear stays set.
- R7: `irq` is high exactly when some status bit is set and its mask bit (bit 0 for ready, bit 1 for underrun) is one.
- R8: Each channel adds its sample XOR 0x8000 to a 16-bit accumulator on every enabled cycle and emits the carry. Counting from a fresh enable, the number of ones on a channel equals the floor of the running sum of those offset values, one term per frame, divided by 256. Channel 0 (low halfword) drives `dac_out[0]`.
- R9: The register map uses byte addresses: control at 0x00, data at 0x04, status at 0x08, clear at 0x0C, mask at 0x10. A read returns data on `reg_rdata` in the cycle after the request. A data-register read returns the pair currently loaded in the modulators.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, also used for the register bus |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address; bits [1:0] must be zero |
| reg_wdata | input | SAMPLE_W*NUM_CH | Write data |
| reg_rdata | output | SAMPLE_W*NUM_CH | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Masked OR of the status bits |
| dac_out | output | NUM_CH | One-bit modulator streams, one per channel |

## Verification
Two pairs of functions can fall in the same cycle. A status clear (a status read or a clear-register write) can meet a status set from a frame boundary. A data write can meet the boundary that would otherwise record an underrun. The bench counts clock edges from the enabling write and places accesses so they are captured on exactly the 256th, 512th, 768th or 1024th edge. It then judges the result from the next read: the underrun bit must survive the clear, and a write in the boundary cycle must load the pair with no underrun. Modulator output is judged by counting ones over whole frames against the floor of the running offset sum divided by 256, including full-scale values and repeated frames after underrun.

// File: rtl/sdac_pkg.sv
// Shared constants for the stereo bitstream DAC controller.
// Assumes word-aligned byte addresses on the register bus.
package sdac_pkg;
    // Word indices of the registers (byte address divided by four)
    localparam int A_CTRL = 0;
    localparam int A_DATA = 1;
    localparam int A_STAT = 2;
    localparam int A_CLR  = 3;
    localparam int A_MASK = 4;

    // Status bit positions
    localparam int ST_RDY = 0;
    localparam int ST_UND = 1;
    localparam int ST_W   = 2;
endpackage

// File: rtl/sdac_regs.sv
// Register file and bus decode for the stereo bitstream DAC controller.
// Holds enable, mask and status. Status follows clear-on-read and
// write-one-to-clear rules, and a set in the same cycle wins over a clear.
// Assumes reads and writes are word aligned; misaligned accesses are ignored.
module sdac_regs
    import sdac_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] pair,
    input  logic              ev_rdy,
    input  logic              ev_und,
    output logic              en_q,
    output logic              dwr,
    output logic [ST_W-1:0]   stat_q,
    output logic [ST_W-1:0]   mask_q,
    output logic [ST_W-1:0]   stat_set,
    output logic              irq,
    output logic [WORD_W-1:0] reg_rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  widx;
    logic              aligned;
    logic              hit_ctrl, hit_data, hit_stat, hit_clr, hit_mask;
    logic              en_set;
    logic [ST_W-1:0]   stat_nx;
    logic [WORD_W-1:0] rd_mux;

    // Address decode of the word index
    always_comb begin
        widx     = reg_addr[ADDR_W-1:2];
        aligned  = (reg_addr[1:0] == 2'b00);
        hit_ctrl = aligned && (int'(widx) == A_CTRL);
        hit_data = aligned && (int'(widx) == A_DATA);
        hit_stat = aligned && (int'(widx) == A_STAT);
        hit_clr  = aligned && (int'(widx) == A_CLR);
        hit_mask = aligned && (int'(widx) == A_MASK);
    end

    // Status-set sources and the gated data-write strobe
    always_comb begin
        en_set           = reg_wr && hit_ctrl && reg_wdata[0] && !en_q;
        dwr              = reg_wr && hit_data && en_q;
        stat_set         = '0;
        stat_set[ST_RDY] = ev_rdy || en_set;
        stat_set[ST_UND] = ev_und;
    end

    // Next status: clears first, then sets on top
    always_comb begin
        stat_nx = stat_q;
        if (reg_rd && hit_stat) begin
            stat_nx = '0;
        end
        if (reg_wr && hit_clr) begin
            stat_nx = stat_nx & ~reg_wdata[ST_W-1:0];
        end
        stat_nx = stat_nx | stat_set;
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux[0] = en_q;
        end else if (hit_data) begin
            rd_mux = pair;
        end else if (hit_stat) begin
            rd_mux[ST_W-1:0] = stat_q;
        end else if (hit_mask) begin
            rd_mux[ST_W-1:0] = mask_q;
        end
    end

    // Register state and registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            mask_q    <= '0;
            stat_q    <= '0;
            reg_rdata <= '0;
        end else begin
            if (reg_wr && hit_ctrl) begin
                en_q <= reg_wdata[0];
            end
            if (reg_wr && hit_mask) begin
                mask_q <= reg_wdata[ST_W-1:0];
            end
            stat_q <= stat_nx;
            if (reg_rd) begin
                reg_rdata <= rd_mux;
            end
        end
    end

    // Interrupt line from masked status
    assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/sdac_frame.sv
// Frame sequencer: counts conversion cycles and holds one pending sample
// pair. At each boundary it loads that pair into the modulator inputs and
// reports ready, or reports underrun when nothing was written.
// Assumes FRAME_LEN is a power of two and dwr is already gated by enable.
module sdac_frame #(
    parameter int WORD_W    = 32,
    parameter int FRAME_LEN = 256,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dwr,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              tick,
    output logic              pending_q,
    output logic [WORD_W-1:0] pair_q,
    output logic              ev_rdy,
    output logic              ev_und
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [WORD_W-1:0] hold_q;

    // Boundary strobe and the events it produces
    always_comb begin
        tick   = en && (cnt_q == LAST);
        ev_rdy = tick && (dwr || pending_q);
        ev_und = tick && !dwr && !pending_q;
    end

    // Frame position counter, held at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pending flag: set by a write, consumed by the boundary
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pending_q <= 1'b0;
        end else if (tick) begin
            pending_q <= 1'b0;
        end else if (dwr) begin
            pending_q <= 1'b1;
        end
    end

    // Holding register for the most recent write in the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (dwr) begin
            hold_q <= wdata;
        end
    end

    // Modulator input pair, updated only at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else if (tick && dwr) begin
            pair_q <= wdata;
        end else if (tick && pending_q) begin
            pair_q <= hold_q;
        end
    end
endmodule

// File: rtl/sdac_chan.sv
// First-order delta-sigma modulator for one channel. Converts the signed
// input to offset binary, accumulates it every enabled cycle and emits the
// carry as a registered bit. Cleared and silent while disabled.
module sdac_chan #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                bit_q
);
    localparam int SUM_W = SAMPLE_W + 1;

    logic [SAMPLE_W-1:0] acc_q;
    logic [SAMPLE_W-1:0] ofs;
    logic [SUM_W-1:0]    sum;

    // Offset-binary conversion and accumulator sum with carry
    always_comb begin
        ofs = {~sample[SAMPLE_W-1], sample[SAMPLE_W-2:0]};
        sum = {1'b0, acc_q} + {1'b0, ofs};
    end

    // Accumulator and output bit
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            acc_q <= '0;
            bit_q <= 1'b0;
        end else begin
            acc_q <= sum[SAMPLE_W-1:0];
            bit_q <= sum[SUM_W-1];
        end
    end
endmodule

// File: rtl/sdac_mod.sv
// Bank of per-channel modulators. Channel k takes halfword k of the pair.
module sdac_mod #(
    parameter int SAMPLE_W = 16,
    parameter int NUM_CH   = 2,
    parameter int WORD_W   = SAMPLE_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [WORD_W-1:0] pair,
    output logic [NUM_CH-1:0] bits
);
    // One modulator per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        sdac_chan #(.SAMPLE_W(SAMPLE_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .sample (pair[ch*SAMPLE_W +: SAMPLE_W]),
            .bit_q  (bits[ch])
        );
    end
endmodule

// File: rtl/stereo_sdm_dac.sv
// Top level of the stereo bitstream DAC controller: register file, frame
// sequencer and modulator bank. Single clock domain; the bus clock is the
// conversion clock (256 cycles per sample frame by default).
module stereo_sdm_dac
    import sdac_pkg::*;
#(
    parameter  int SAMPLE_W  = 16,
    parameter  int NUM_CH    = 2,
    parameter  int FRAME_LEN = 256,
    parameter  int ADDR_W    = 5,
    localparam int WORD_W    = SAMPLE_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic [NUM_CH-1:0] dac_out
);
    localparam int CNT_W = $clog2(FRAME_LEN);

    logic              en_q;
    logic              dwr;
    logic [ST_W-1:0]   stat_q;
    logic [ST_W-1:0]   mask_q;
    logic [ST_W-1:0]   stat_set;
    logic [CNT_W-1:0]  cnt_q;
    logic              tick;
    logic              pending_q;
    logic [WORD_W-1:0] pair_q;
    logic              ev_rdy;
    logic              ev_und;

    sdac_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pair      (pair_q),
        .ev_rdy    (ev_rdy),
        .ev_und    (ev_und),
        .en_q      (en_q),
        .dwr       (dwr),
        .stat_q    (stat_q),
        .mask_q    (mask_q),
        .stat_set  (stat_set),
        .irq       (irq),
        .reg_rdata (reg_rdata)
    );

    sdac_frame #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .dwr       (dwr),
        .wdata     (reg_wdata),
        .cnt_q     (cnt_q),
        .tick      (tick),
        .pending_q (pending_q),
        .pair_q    (pair_q),
        .ev_rdy    (ev_rdy),
        .ev_und    (ev_und)
    );

    sdac_mod #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_mod (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .pair  (pair_q),
        .bits  (dac_out)
    );
endmodule

// File: rtl/sdac_chk.sv
// Assertion checker for stereo_sdm_dac, attached by bind below.
module sdac_chk
    import sdac_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int WORD_W = 32,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_q,
    input logic              tick,
    input logic              pending_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [WORD_W-1:0] pair_q,
    input logic [ST_W-1:0]   stat_q,
    input logic [ST_W-1:0]   mask_q,
    input logic [ST_W-1:0]   stat_set,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq,
    input logic [NUM_CH-1:0] dac_out
);
    logic rd_stat;
    assign rd_stat = reg_rd && (reg_addr == ADDR_W'(A_STAT * 4));

    assert_dout_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (dac_out == '0));

    assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (cnt_q == '0));

    assert_und_at_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_UND]) |-> $past(tick));

    assert_pair_at_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pair_q) |-> $past(tick));

    assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !pending_q);

    assert_rd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && (stat_set == '0)) |=> (stat_q == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_set[ST_UND] |=> stat_q[ST_UND]);

    assert_irq_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    assert_irq_stat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq);
endmodule

bind stereo_sdm_dac sdac_chk #(
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W),
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .tick      (tick),
    .pending_q (pending_q),
    .cnt_q     (cnt_q),
    .pair_q    (pair_q),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .stat_set  (stat_set),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .irq       (irq),
    .dac_out   (dac_out)
);

// File: tb/sim_stereo_sdm_dac.sv
`timescale 1ns/1ps
module sim_stereo_sdm_dac;
    localparam logic [4:0] AD_CTRL = 5'h00;
    localparam logic [4:0] AD_DATA = 5'h04;
    localparam logic [4:0] AD_STAT = 5'h08;
    localparam logic [4:0] AD_CLR  = 5'h0C;
    localparam logic [4:0] AD_MASK = 5'h10;
    localparam int NFR = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [1:0]  dac_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    longint ecnt = 0;
    longint e0 = 0;
    bit cnt_on = 1'b0;
    int ones0 = 0;
    int ones1 = 0;

    always #2.5 clk = ~clk;

    stereo_sdm_dac u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .dac_out(dac_out)
    );

    always @(posedge clk) ecnt <= ecnt + 1;

    always @(negedge clk) begin
        if (cnt_on) begin
            ones0 <= ones0 + int'(dac_out[0]);
            ones1 <= ones1 + int'(dac_out[1]);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // Wait until the negedge after edge e0+k
    task automatic wait_to(input longint k);
        while (ecnt < e0 + k) @(negedge clk);
    endtask

    function automatic logic [31:0] samp(input int f);
        logic [15:0] a, b;
        a = 16'(f * 3277) ^ 16'h8000;
        b = 16'(32767 - f * 3449);
        if (f == 2) begin a = 16'h7FFF; b = 16'h8000; end
        if (f == 3) begin a = 16'h8000; b = 16'h7FFF; end
        return {b, a};
    endfunction

    initial begin
        logic [31:0] d;
        logic [31:0] cur;
        logic [31:0] nxt;
        longint s0, s1;
        int bad;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 dac_out", {30'b0, dac_out}, 32'h0);
        rd(AD_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(AD_MASK, d); chk("R1 mask", d, 32'h0);
        rd(AD_STAT, d); chk("R1 stat", d, 32'h0);

        // R2: data write while disabled is ignored, no status, no output
        wr(AD_DATA, 32'hDEAD_BEEF);
        bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (dac_out != 2'b00) bad++;
        end
        chk("R2 idle output", bad, 0);
        rd(AD_DATA, d); chk("R2 data ignored", d, 32'h0);
        rd(AD_STAT, d); chk("R2 no status", d, 32'h0);

        // Enable; edge e0 captures it
        wr(AD_CTRL, 32'h1);
        e0 = ecnt;
        rd(AD_CTRL, d); chk("R9 ctrl readback", d, 32'h1);
        wait_to(254);
        rd(AD_STAT, d); chk("R3 ready on enable, R4 no early underrun", d, 32'h1);
        rd(AD_STAT, d); chk("R6 read at boundary sees old value", d, 32'h0);
        rd(AD_STAT, d); chk("R4 underrun at boundary, R6 set wins", d, 32'h2);
        rd(AD_STAT, d); chk("R6 cleared by read", d, 32'h0);
        rd(AD_DATA, d); chk("R4 pair kept on underrun", d, 32'h0);

        // R6: write-one-to-clear
        wait_to(512);
        wr(AD_CLR, 32'h2);
        rd(AD_STAT, d); chk("R6 clear register", d, 32'h0);

        // R6: clear and set in the same cycle
        wait_to(767);
        wr(AD_CLR, 32'h3);
        rd(AD_STAT, d); chk("R6 set beats clear", d, 32'h2);

        // R5: write captured in the boundary cycle
        wait_to(1023);
        wr(AD_DATA, 32'hA5A5_0F0F);
        rd(AD_DATA, d); chk("R5 boundary write loaded", d, 32'hA5A5_0F0F);
        rd(AD_STAT, d); chk("R5 boundary write on time, R3 ready", d, 32'h1);

        // R5: mid-frame write waits for the boundary
        wr(AD_DATA, 32'h1234_8001);
        rd(AD_DATA, d); chk("R5 not loaded mid-frame", d, 32'hA5A5_0F0F);
        wait_to(1279);
        rd(AD_DATA, d); chk("R5 read at boundary sees old pair", d, 32'hA5A5_0F0F);
        rd(AD_DATA, d); chk("R5 loaded after boundary", d, 32'h1234_8001);

        // R5: last write in a frame wins
        wr(AD_DATA, 32'h1111_2222);
        wr(AD_DATA, 32'h7FFF_8000);
        wait_to(1536);
        rd(AD_DATA, d); chk("R5 last write wins", d, 32'h7FFF_8000);
        rd(AD_STAT, d); chk("R3 ready at loading boundaries", d, 32'h1);

        // R7: interrupt masking
        wr(AD_MASK, 32'h2);
        rd(AD_MASK, d); chk("R9 mask readback", d, 32'h2);
        chk("R7 irq low with empty status", {31'b0, irq}, 32'h0);
        wait_to(1792);
        chk("R7 irq on masked underrun", {31'b0, irq}, 32'h1);
        wr(AD_MASK, 32'h1);
        chk("R7 irq low when bit masked off", {31'b0, irq}, 32'h0);
        wr(AD_MASK, 32'h3);
        chk("R7 irq high again", {31'b0, irq}, 32'h1);
        rd(AD_STAT, d); chk("R4 repeated underrun", d, 32'h2);
        chk("R7 irq low after status read", {31'b0, irq}, 32'h0);
        rd(AD_DATA, d); chk("R4 pair still converting", d, 32'h7FFF_8000);

        // R2: disable, outputs silent, writes ignored, no status
        wr(AD_CTRL, 32'h0);
        wr(AD_DATA, 32'h0BAD_0BAD);
        bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (dac_out != 2'b00) bad++;
        end
        chk("R2 silent after disable", bad, 0);
        rd(AD_DATA, d); chk("R2 write ignored after disable", d, 32'h7FFF_8000);
        rd(AD_STAT, d); chk("R2 no status while disabled", d, 32'h0);
        wr(AD_MASK, 32'h0);

        // R8: density sweep over frames from a fresh enable
        cur = 32'h7FFF_8000;
        s0 = 0; s1 = 0;
        wr(AD_CTRL, 32'h1);
        e0 = ecnt;
        ones0 = 0; ones1 = 0;
        cnt_on = 1'b1;
        for (int f = 0; f < NFR; f++) begin
            if ((f + 1) % 6 == 5) begin
                nxt = cur;
            end else begin
                nxt = samp(f + 1);
                wr(AD_DATA, nxt);
            end
            wait_to(256 * (f + 1));
            #1;
            s0 += longint'(cur[15:0] ^ 16'h8000);
            s1 += longint'(cur[31:16] ^ 16'h8000);
            chk($sformatf("R8 ch0 ones frame %0d", f), ones0, 32'(s0 / 256));
            chk($sformatf("R8 ch1 ones frame %0d", f), ones1, 32'(s1 / 256));
            cur = nxt;
        end
        cnt_on = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule